// File: doc/BRIEF.md
# Colour Map Palette Unit

This block holds the colour lookup table of a pixel display path. A host programs it over a narrow 32-bit register bus. One write selects an entry. After that, three accesses to a data port move the red, green and blue bytes of that entry in turn. Once the third byte is done, the entry pointer steps forward on its own, so a whole table can be loaded or dumped as one run of data accesses. A second data port loads a small overlay bank of four entries. The bank is addressed by the two low bits of the same pointer, and two of its entries drive the cursor colour outputs.

The display pipeline uses a separate stream port. It presents an 8-bit pixel code with a valid/ready handshake and receives the 24-bit colour one cycle later on an output stream that honours back-pressure. While the output holds a result that has not been taken (`rgb_valid` high, `rgb_ready` low), the result stays stable and `pix_ready` is low, so no new code is accepted. A table write becomes visible to lookups accepted in any later cycle.

Register bus: an access is one cycle with `bus_sel` high. It counts only when all four byte enables are set and the address is word aligned. Read data returns one cycle later, marked by `bus_rvalid`.

Top module: `cmap_dac`

## Requirements
- R1: A counted write to word offset 0x0 loads the entry pointer from `bus_wdata[31:24]` and returns the colour step to red.
- R2: Counted writes to offset 0x4 store `bus_wdata[31:24]` into the red, then green, then blue byte of the pixel entry at the pointer. After the blue byte the pointer increments modulo 256 (0xFF becomes 0x00) and the step returns to red.
- R3: Counted writes to offset 0xC store the bytes in the same red, green, blue order into overlay slot `pointer[1:0]`, leaving the pixel entries unchanged. The pointer advances exactly as in R2.
- R4: A counted read at any word offset returns, one cycle later with `bus_rvalid` high, the current byte (red, green, then blue) of the pixel entry at the pointer in bits 31:24, with bits 23:0 zero. It advances the step and pointer as in R2.
- R5: After reset, all entries are zero except pixel entry 255 and overlay slots 0 and 2, which are 0xFFFFFF. Pointer and step are zero, and `rgb_valid` and `bus_rvalid` are low.
- R6: An access with any byte enable clear, an access whose address has nonzero bits 1:0, and a write to offset 0x8 are ignored: no entry, pointer or step changes, and a read so ignored gives no `bus_rvalid`.
- R7: A pixel code accepted (`pix_valid` and `pix_ready` high) at one clock edge appears at the next edge on `rgb_data` as red in bits 23:16, green in 15:8 and blue in 7:0, with `rgb_valid` high.
- R8: While `rgb_valid` is high and `rgb_ready` is low, `pix_ready` is low and `rgb_valid` and `rgb_data` hold their values.
- R9: `cur_bg` continuously shows overlay slot 2 and `cur_fg` shows overlay slot 3, each in the same red, green, blue packing as R7.
- R10: A lookup accepted after a table write completes returns the newly written colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_be | input | 4 | Byte enables; all must be set |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid (one cycle after a counted read) |
| bus_rdata | output | 32 | Read data, byte in bits 31:24 |
| pix_valid | input | 1 | Pixel code valid |
| pix_ready | output | 1 | Pixel code can be accepted |
| pix_code | input | 8 | Pixel code to translate |
| rgb_valid | output | 1 | Colour result valid |
| rgb_ready | input | 1 | Downstream takes the colour result |
| rgb_data | output | 24 | Colour result |
| cur_bg | output | 24 | Cursor colour from overlay slot 2 |
| cur_fg | output | 24 | Cursor colour from overlay slot 3 |

## Verification
The assertions check the sequencing rules on every cycle. An index load resets the step. A blue-step data write wraps the step and increments the pointer, for the pixel and the overlay port alike. Partial-width accesses leave the pointer and step untouched. Read data is flagged exactly one cycle after a counted read, with zero low bits. The lookup stream accepts, holds under back-pressure and raises valid one cycle after acceptance. The actual colour contents can only be shown by the bench's scenarios, which write values and read them back through lookups, register reads and the cursor outputs: the byte-order mapping, the overlay slot choice, wrap from 0xFF to 0x00, reset contents and write-to-lookup visibility.

// File: rtl/cmap_pkg.sv
package cmap_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam logic [3:0] OFS_INDEX   = 4'h0;
  localparam logic [3:0] OFS_PIXEL   = 4'h4;
  localparam logic [3:0] OFS_OVERLAY = 4'hC;

  localparam int CUR_BG_SLOT = 2;
  localparam int CUR_FG_SLOT = 3;

  localparam rgb_t RGB_WHITE = rgb_t'(24'hFFFFFF);

  function automatic rgb_t put_chan(rgb_t cur, phase_e ph, logic [7:0] v);
    rgb_t n;
    n = cur;
    case (ph)
      PH_RED:  n.r = v;
      PH_GRN:  n.g = v;
      default: n.b = v;
    endcase
    return n;
  endfunction

  function automatic logic [7:0] get_chan(rgb_t c, phase_e ph);
    case (ph)
      PH_RED:  return c.r;
      PH_GRN:  return c.g;
      default: return c.b;
    endcase
  endfunction

endpackage

// File: rtl/cmap_seq.sv
module cmap_seq
  import cmap_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W/8-1:0]   bus_be,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [IDX_W-1:0]      idx,
  output phase_e                phase,
  output logic                  wr_pix,
  output logic                  wr_ovl,
  output logic                  rd_fire,
  output logic [7:0]            wr_byte
);

  localparam int BYTE_LSB = DATA_W - 8;

  logic full_word, acc, ld_idx, step;
  logic unused_wdata;

  assign full_word = (&bus_be) && (bus_addr[1:0] == 2'b00);
  assign acc       = bus_sel && full_word;
  assign ld_idx    = acc && bus_wr && (bus_addr == ADDR_W'(OFS_INDEX));
  assign wr_pix    = acc && bus_wr && (bus_addr == ADDR_W'(OFS_PIXEL));
  assign wr_ovl    = acc && bus_wr && (bus_addr == ADDR_W'(OFS_OVERLAY));
  assign rd_fire   = acc && !bus_wr;
  assign step      = wr_pix || wr_ovl || rd_fire;
  assign wr_byte   = bus_wdata[DATA_W-1:BYTE_LSB];

  assign unused_wdata = ^bus_wdata[BYTE_LSB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (ld_idx) begin
      idx   <= bus_wdata[DATA_W-1 -: IDX_W];
      phase <= PH_RED;
    end else if (step) begin
      if (phase == PH_BLU) begin
        idx   <= idx + IDX_W'(1);
        phase <= PH_RED;
      end else begin
        phase <= phase_e'(phase + 2'd1);
      end
    end
  end

endmodule

// File: rtl/cmap_store.sv
module cmap_store
  import cmap_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int OVL_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_pix,
  input  logic             wr_ovl,
  input  logic [IDX_W-1:0] wr_idx,
  input  phase_e           wr_ph,
  input  logic [7:0]       wr_byte,
  output logic [7:0]       rd_byte,
  input  logic [IDX_W-1:0] lk_code,
  output rgb_t             lk_rgb,
  output rgb_t             cur_bg,
  output rgb_t             cur_fg
);

  localparam int NPIX  = 1 << IDX_W;
  localparam int OVL_W = $clog2(OVL_N);

  rgb_t pix_mem [NPIX];
  rgb_t ovl_mem [OVL_N];

  logic [OVL_W-1:0] ovl_slot;
  assign ovl_slot = wr_idx[OVL_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPIX; i++)
        pix_mem[i] <= (i == NPIX - 1) ? RGB_WHITE : '0;
    end else if (wr_pix) begin
      pix_mem[wr_idx] <= put_chan(pix_mem[wr_idx], wr_ph, wr_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < OVL_N; i++)
        ovl_mem[i] <= (i == 0 || i == CUR_BG_SLOT) ? RGB_WHITE : '0;
    end else if (wr_ovl) begin
      ovl_mem[ovl_slot] <= put_chan(ovl_mem[ovl_slot], wr_ph, wr_byte);
    end
  end

  assign rd_byte = get_chan(pix_mem[wr_idx], wr_ph);
  assign lk_rgb  = pix_mem[lk_code];
  assign cur_bg  = ovl_mem[CUR_BG_SLOT];
  assign cur_fg  = ovl_mem[CUR_FG_SLOT];

endmodule

// File: rtl/cmap_lookup.sv
module cmap_lookup #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

endmodule

// File: rtl/cmap_dac.sv
module cmap_dac
  import cmap_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8,
  parameter int OVL_N  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_rvalid,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                pix_valid,
  output logic                pix_ready,
  input  logic [IDX_W-1:0]    pix_code,
  output logic                rgb_valid,
  input  logic                rgb_ready,
  output logic [23:0]         rgb_data,
  output logic [23:0]         cur_bg,
  output logic [23:0]         cur_fg
);

  logic [IDX_W-1:0] idx;
  phase_e           phase;
  logic             wr_pix, wr_ovl, rd_fire;
  logic [7:0]       wr_byte, rd_byte;
  rgb_t             lk_rgb, bg_rgb, fg_rgb;

  cmap_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_seq (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata,
    .idx, .phase, .wr_pix, .wr_ovl, .rd_fire, .wr_byte
  );

  cmap_store #(.IDX_W(IDX_W), .OVL_N(OVL_N)) u_store (
    .clk, .rst_n, .wr_pix, .wr_ovl,
    .wr_idx(idx), .wr_ph(phase), .wr_byte, .rd_byte,
    .lk_code(pix_code), .lk_rgb, .cur_bg(bg_rgb), .cur_fg(fg_rgb)
  );

  cmap_lookup #(.W(24)) u_lookup (
    .clk, .rst_n,
    .in_valid(pix_valid), .in_ready(pix_ready), .in_data(lk_rgb),
    .out_valid(rgb_valid), .out_ready(rgb_ready), .out_data(rgb_data)
  );

  assign cur_bg = bg_rgb;
  assign cur_fg = fg_rgb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_fire;
      if (rd_fire) bus_rdata <= {rd_byte, {(DATA_W-8){1'b0}}};
    end
  end

endmodule

// File: rtl/cmap_dac_chk.sv
module cmap_dac_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [3:0]  bus_addr,
  input logic [3:0]  bus_be,
  input logic [31:0] bus_wdata,
  input logic        bus_rvalid,
  input logic [31:0] bus_rdata,
  input logic        pix_valid,
  input logic        pix_ready,
  input logic        rgb_valid,
  input logic        rgb_ready,
  input logic [23:0] rgb_data,
  input logic [7:0]  idx,
  input logic [1:0]  phase
);

  logic cnt_acc;
  assign cnt_acc = bus_sel && (&bus_be) && (bus_addr[1:0] == 2'b00);

  a_r1_index_load: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_acc && bus_wr && bus_addr == 4'h0
      |=> idx == $past(bus_wdata[31:24]) && phase == 2'd0);

  a_r2_pixel_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_acc && bus_wr && bus_addr == 4'h4 && phase == 2'd2
      |=> phase == 2'd0 && idx == 8'($past(idx) + 8'd1));

  a_r3_overlay_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_acc && bus_wr && bus_addr == 4'hC && phase == 2'd2
      |=> phase == 2'd0 && idx == 8'($past(idx) + 8'd1));

  a_r4_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_acc && !bus_wr |=> bus_rvalid);

  a_r4_no_spurious_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !(cnt_acc && !bus_wr) |=> !bus_rvalid);

  a_r4_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> bus_rdata[23:0] == 24'h0);

  a_r6_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && !(&bus_be) |=> $stable(idx) && $stable(phase));

  a_r7_accept_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> rgb_valid);

  a_r8_stall_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid && !rgb_ready |-> !pix_ready);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rgb_valid && !rgb_ready |=> rgb_valid && $stable(rgb_data));

endmodule

bind cmap_dac cmap_dac_chk u_chk (
  .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata,
  .bus_rvalid, .bus_rdata, .pix_valid, .pix_ready, .rgb_valid,
  .rgb_ready, .rgb_data, .idx, .phase
);

// File: tb/tb_cmap_dac.sv
`timescale 1ns/1ps
module tb_cmap_dac;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [3:0]  bus_addr, bus_be;
  logic [31:0] bus_wdata;
  logic        bus_rvalid;
  logic [31:0] bus_rdata;
  logic        pix_valid, pix_ready;
  logic [7:0]  pix_code;
  logic        rgb_valid, rgb_ready;
  logic [23:0] rgb_data, cur_bg, cur_fg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmap_dac dut (
    .clk, .rst_n, .bus_sel, .bus_wr, .bus_addr, .bus_be, .bus_wdata,
    .bus_rvalid, .bus_rdata, .pix_valid, .pix_ready, .pix_code,
    .rgb_valid, .rgb_ready, .rgb_data, .cur_bg, .cur_fg
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic v, output logic [31:0] d,
                          input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 0;
    v = bus_rvalid; d = bus_rdata;
  endtask

  task automatic lookup(input logic [7:0] code, output logic v, output logic [23:0] d);
    @(negedge clk);
    pix_valid = 1; pix_code = code;
    @(negedge clk);
    pix_valid = 0;
    v = rgb_valid; d = rgb_data;
  endtask

  task automatic set_rgb(input logic [3:0] port, input logic [23:0] c);
    bus_write(port, {c[23:16], 24'h0});
    bus_write(port, {c[15:8], 24'h0});
    bus_write(port, {c[7:0], 24'h0});
  endtask

  task automatic t_reset;
    logic v; logic [23:0] d; logic [31:0] rd;
    chk("R5 rgb_valid after reset", rgb_valid, 0);
    chk("R5 bus_rvalid after reset", bus_rvalid, 0);
    chk("R5/R9 cur_bg reset white", cur_bg, 24'hFFFFFF);
    chk("R5/R9 cur_fg reset zero", cur_fg, 24'h0);
    lookup(8'd0, v, d);   chk("R5 entry 0 zero", d, 24'h0);
    lookup(8'd255, v, d); chk("R5 entry 255 white", d, 24'hFFFFFF);
    lookup(8'd128, v, d); chk("R5 entry 128 zero", d, 24'h0);
    bus_read(4'h4, v, rd); chk("R5 pointer 0 red read", rd, 32'h0);
  endtask

  task automatic t_pixel_write;
    logic v; logic [23:0] d;
    bus_write(4'h0, 32'h1000_0000);
    set_rgb(4'h4, 24'h123456);
    set_rgb(4'h4, 24'hABCDEF);
    lookup(8'h10, v, d);
    chk("R7 lookup valid after one cycle", v, 1);
    chk("R2/R10 entry 0x10", d, 24'h123456);
    lookup(8'h11, v, d);
    chk("R2 auto increment entry 0x11", d, 24'hABCDEF);
  endtask

  task automatic t_readback;
    logic v; logic [31:0] rd;
    logic [7:0] exp_b [6] = '{8'h12, 8'h34, 8'h56, 8'hAB, 8'hCD, 8'hEF};
    bus_write(4'h0, 32'h1000_0000);
    for (int i = 0; i < 6; i++) begin
      bus_read(4'h4, v, rd);
      chk("R4 read flag", v, 1);
      chk("R4 read byte order", rd, {exp_b[i], 24'h0});
    end
  endtask

  task automatic t_wrap;
    logic v; logic [23:0] d;
    bus_write(4'h0, 32'hFF00_0000);
    set_rgb(4'h4, 24'h0A0B0C);
    set_rgb(4'h4, 24'h778899);
    lookup(8'hFF, v, d); chk("R2 entry 0xFF written", d, 24'h0A0B0C);
    lookup(8'h00, v, d); chk("R2 pointer wraps to 0x00", d, 24'h778899);
  endtask

  task automatic t_overlay;
    logic v; logic [23:0] d;
    bus_write(4'h0, 32'h0600_0000);
    set_rgb(4'hC, 24'hA1B2C3);
    chk("R3/R9 slot 2 on cur_bg", cur_bg, 24'hA1B2C3);
    set_rgb(4'hC, 24'h112233);
    chk("R3/R9 slot 3 on cur_fg", cur_fg, 24'h112233);
    lookup(8'h06, v, d); chk("R3 pixel entry 6 untouched", d, 24'h0);
    lookup(8'h07, v, d); chk("R3 pixel entry 7 untouched", d, 24'h0);
  endtask

  task automatic t_ignored;
    logic v; logic [23:0] d; logic [31:0] rd;
    bus_write(4'h0, 32'h2000_0000);
    bus_write(4'h4, 32'h9900_0000, 4'b0111);
    bus_write(4'h8, 32'h5500_0000);
    bus_write(4'h5, 32'h6600_0000);
    bus_write(4'h0, 32'h4000_0000, 4'b1110);
    bus_read(4'h4, v, rd, 4'b0011);
    chk("R6 partial read gives no flag", v, 0);
    set_rgb(4'h4, 24'h010203);
    lookup(8'h20, v, d); chk("R6 ignored accesses left step and pointer", d, 24'h010203);
    lookup(8'h40, v, d); chk("R6 partial index write ignored", d, 24'h0);
  endtask

  task automatic t_phase_reset;
    logic v; logic [23:0] d;
    bus_write(4'h0, 32'h3000_0000);
    bus_write(4'h4, 32'h4400_0000);
    bus_write(4'h4, 32'h5500_0000);
    bus_write(4'h0, 32'h3000_0000);
    set_rgb(4'h4, 24'h667788);
    lookup(8'h30, v, d); chk("R1 index write restarts at red", d, 24'h667788);
    lookup(8'h31, v, d); chk("R1 next entry untouched", d, 24'h0);
  endtask

  task automatic t_backpressure;
    @(negedge clk);
    rgb_ready = 0; pix_valid = 1; pix_code = 8'h10;
    @(negedge clk);
    chk("R7 stalled result valid", rgb_valid, 1);
    chk("R7 stalled result data", rgb_data, 24'h123456);
    chk("R8 ready low while stalled", pix_ready, 0);
    pix_code = 8'h11;
    @(negedge clk);
    chk("R8 data held under stall", rgb_data, 24'h123456);
    chk("R8 valid held under stall", rgb_valid, 1);
    rgb_ready = 1;
    @(negedge clk);
    pix_valid = 0;
    chk("R8 next code after release", rgb_data, 24'hABCDEF);
    @(negedge clk);
    chk("R8 valid drops when idle", rgb_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_be = 4'hF;
    bus_wdata = 0; pix_valid = 0; pix_code = 0; rgb_ready = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_pixel_write();
    t_readback();
    t_wrap();
    t_overlay();
    t_ignored();
    t_phase_reset();
    t_backpressure();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule